// File: doc/BRIEF.md
# Dual-Chain Carry-Select Adder/Subtractor with Output Register

This block is an N-bit arithmetic datapath made of identical bit cells. Every cell works out, in parallel, the sum bit and carry-out it would give under an incoming carry of 0 and under an incoming carry of 1. Two carry chains run the whole width side by side. One starts from a forced 0 and the other from a forced 1, and each cell passes on the carry chosen by its own chain's carry-in. A single late block-level carry picks one chain. Along that chain, each bit's carry selects which of the cell's two precomputed sums reaches the output. The carry does not ripple a single chain after it arrives.

A shared subtract control inverts the second operand and forces the effective carry to 1, so the result is two's-complement `data1 - data2`. The combinational sum and carry-out are presented directly. A register stage captures them with clock enable, synchronous clear and synchronous load. An operating-mode input feeds the registered sum back as the first operand. With that feedback the block runs as an accumulator, or as an up/down counter in which the second operand is the constant 1.

The register's per-edge action is an enumerated choice. The actions are HOLD (clock enable low, or counter enable low in counter mode), CLEAR, LOAD and STEP. The transitions on each enabled edge are taken in priority order: to CLEAR when clear is high, otherwise to LOAD when load is high, otherwise to STEP when an update is allowed, otherwise to HOLD. The operand modes are PLAIN (`op_mode` 00, and 11 also behaves as PLAIN), ACCUM (01) and COUNT (10).

Top module: `csel_addsub`

## Requirements
- R1: In PLAIN mode with `sub_en`=0, `{comb_cout, comb_sum}` equals `data1 + data2 + carry_in` taken as a WIDTH+1 bit result.
- R2: In PLAIN mode with `sub_en`=1, `comb_sum` equals `data1 - data2` modulo 2^WIDTH, `comb_cout` is 1 exactly when `data1 >= data2` (unsigned), and `carry_in` has no effect.
- R3: With the operands fixed in add mode, changing `carry_in` from 0 to 1 raises the WIDTH+1 bit result by exactly one, including a carry through every bit (all-ones plus carry gives zero with carry-out 1).
- R4: On a rising edge with `ena`=1, `sclr`=0, `sload`=0 and an update allowed, `reg_sum`/`reg_cout` take the values `comb_sum`/`comb_cout` had before the edge.
- R5: On a rising edge with `ena`=1 and `sclr`=1, `reg_sum` and `reg_cout` become 0 whatever `sload` is.
- R6: On a rising edge with `ena`=1, `sclr`=0 and `sload`=1, `reg_sum` takes `load_val` and `reg_cout` becomes 0, whatever the mode and operands are.
- R7: With `ena`=0, `reg_sum` and `reg_cout` keep their values even when `sclr` or `sload` is high.
- R8: In ACCUM mode the first operand is `reg_sum`, so each update gives `reg_sum + data2 + carry_in` (add) or `reg_sum - data2` (subtract).
- R9: In COUNT mode each update gives `reg_sum + 1` when `cnt_down`=0 and `reg_sum - 1` when `cnt_down`=1, with wrap-around at both ends. `data1`, `data2`, `carry_in` and `sub_en` are ignored in this mode.
- R10: In COUNT mode with `cnt_en`=0, an edge with `ena`=1, `sclr`=0 and `sload`=0 leaves the register unchanged.
- R11: While `rst_n` is low, `reg_sum` and `reg_cout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_mode | input | 2 | 00 PLAIN, 01 ACCUM, 10 COUNT, 11 PLAIN |
| data1 | input | WIDTH | First operand (PLAIN mode only) |
| data2 | input | WIDTH | Second operand (PLAIN and ACCUM) |
| carry_in | input | 1 | Late block carry, add mode only |
| sub_en | input | 1 | 1 selects subtraction (PLAIN and ACCUM) |
| ena | input | 1 | Clock enable for the whole register stage |
| cnt_en | input | 1 | Update enable in COUNT mode |
| cnt_down | input | 1 | 1 counts down in COUNT mode |
| sclr | input | 1 | Synchronous clear, highest priority |
| sload | input | 1 | Synchronous load of `load_val` |
| load_val | input | WIDTH | Parallel load value |
| comb_sum | output | WIDTH | Unregistered sum |
| comb_cout | output | 1 | Unregistered carry-out |
| reg_sum | output | WIDTH | Registered sum |
| reg_cout | output | 1 | Registered carry-out |

## Verification
The bench builds the block with WIDTH=8. At that width, all-ones-plus-carry, zero-minus-one and counter wrap at both ends are reached in a handful of steps. A few thousand random operand pairs also cover a useful share of the 65,536-pair space for both carry values and both operations. The same width keeps accumulator sequences short enough to follow step by step against a running model in the bench.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_ACCUM = 2'b01,
        MODE_COUNT = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } act_e;

endpackage

// File: rtl/csel_cell.sv
// One bit slice: four 2-input functions give sum and carry for both carry
// assumptions; each chain's carry-in picks that chain's carry-out.
module csel_cell (
    input  logic a,
    input  logic b,
    input  logic ci_z,
    input  logic ci_o,
    output logic co_z,
    output logic co_o,
    output logic s_z,
    output logic s_o
);
    logic sum_if0, sum_if1, car_if0, car_if1;

    always_comb begin
        sum_if0 = a ^ b;
        sum_if1 = ~(a ^ b);
        car_if0 = a & b;
        car_if1 = a | b;
        co_z    = ci_z ? car_if1 : car_if0;
        co_o    = ci_o ? car_if1 : car_if0;
        s_z     = ci_z ? sum_if1 : sum_if0;
        s_o     = ci_o ? sum_if1 : sum_if0;
    end
endmodule

// File: rtl/csel_chain.sv
module csel_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0]   chain_z, chain_o;
    logic [WIDTH-1:0] sum_z, sum_o;

    assign chain_z[0] = 1'b0;
    assign chain_o[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        csel_cell u_cell (
            .a    (op_a[i]),
            .b    (op_b[i]),
            .ci_z (chain_z[i]),
            .ci_o (chain_o[i]),
            .co_z (chain_z[i+1]),
            .co_o (chain_o[i+1]),
            .s_z  (sum_z[i]),
            .s_o  (sum_o[i])
        );
    end

    // late carry chooses one whole chain
    always_comb begin
        sum  = cin ? sum_o : sum_z;
        cout = cin ? chain_o[WIDTH] : chain_z[WIDTH];
    end

    always_comb begin
        // R3: the chain seeded with 1 never carries less than the chain seeded with 0
        a_r3_chain_order: assert ((chain_z & ~chain_o) == '0);
        // R1: selected chain agrees with plain binary addition
        a_r1_sum_ref: assert ({cout, sum} ==
            ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin}));
    end
endmodule

// File: rtl/csel_front.sv
module csel_front
    import csel_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  mode_e            mode,
    input  logic [WIDTH-1:0] data1,
    input  logic [WIDTH-1:0] data2,
    input  logic             carry_in,
    input  logic             sub_en,
    input  logic             cnt_down,
    input  logic [WIDTH-1:0] fb,
    output logic [WIDTH-1:0] op_a,
    output logic [WIDTH-1:0] op_b,
    output logic             cin
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (mode)
            MODE_COUNT: begin
                op_a = fb;
                op_b = cnt_down ? ~ONE : ONE;
                cin  = cnt_down;
            end
            MODE_ACCUM: begin
                op_a = fb;
                op_b = sub_en ? ~data2 : data2;
                cin  = sub_en | carry_in;
            end
            default: begin
                op_a = data1;
                op_b = sub_en ? ~data2 : data2;
                cin  = sub_en | carry_in;
            end
        endcase
    end
endmodule

// File: rtl/csel_outreg.sv
module csel_outreg
    import csel_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic             sclr,
    input  logic             sload,
    input  logic             upd_ok,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] nxt_sum,
    input  logic             nxt_cout,
    output logic [WIDTH-1:0] q,
    output logic             qc
);
    act_e             act;
    logic [WIDTH-1:0] q_d;
    logic             qc_d;

    always_comb begin
        if (!ena)        act = ACT_HOLD;
        else if (sclr)   act = ACT_CLEAR;
        else if (sload)  act = ACT_LOAD;
        else if (upd_ok) act = ACT_STEP;
        else             act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR: begin q_d = '0;       qc_d = 1'b0;     end
            ACT_LOAD:  begin q_d = load_val; qc_d = 1'b0;     end
            ACT_STEP:  begin q_d = nxt_sum;  qc_d = nxt_cout; end
            default:   begin q_d = q;        qc_d = qc;       end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q  <= '0;
            qc <= 1'b0;
        end else begin
            q  <= q_d;
            qc <= qc_d;
        end
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ena |=> ($stable(q) && $stable(qc)));
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && sclr) |=> (q == '0 && !qc));
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && !sclr && sload) |=> (q == $past(load_val) && !qc));
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && !sclr && !sload && upd_ok) |=> (q == $past(nxt_sum) && qc == $past(nxt_cout)));
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && !sclr && !sload && !upd_ok) |=> $stable(q));
endmodule

// File: rtl/csel_addsub.sv
module csel_addsub
    import csel_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_mode,
    input  logic [WIDTH-1:0] data1,
    input  logic [WIDTH-1:0] data2,
    input  logic             carry_in,
    input  logic             sub_en,
    input  logic             ena,
    input  logic             cnt_en,
    input  logic             cnt_down,
    input  logic             sclr,
    input  logic             sload,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] comb_sum,
    output logic             comb_cout,
    output logic [WIDTH-1:0] reg_sum,
    output logic             reg_cout
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    mode_e            mode;
    logic [WIDTH-1:0] op_a, op_b;
    logic             cin, upd_ok;

    always_comb begin
        unique case (op_mode)
            2'b01:   mode = MODE_ACCUM;
            2'b10:   mode = MODE_COUNT;
            default: mode = MODE_PLAIN;
        endcase
        upd_ok = (mode == MODE_COUNT) ? cnt_en : 1'b1;
    end

    csel_front #(.WIDTH(WIDTH)) u_front (
        .mode     (mode),
        .data1    (data1),
        .data2    (data2),
        .carry_in (carry_in),
        .sub_en   (sub_en),
        .cnt_down (cnt_down),
        .fb       (reg_sum),
        .op_a     (op_a),
        .op_b     (op_b),
        .cin      (cin)
    );

    csel_chain #(.WIDTH(WIDTH)) u_chain (
        .op_a (op_a),
        .op_b (op_b),
        .cin  (cin),
        .sum  (comb_sum),
        .cout (comb_cout)
    );

    csel_outreg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ena      (ena),
        .sclr     (sclr),
        .sload    (sload),
        .upd_ok   (upd_ok),
        .load_val (load_val),
        .nxt_sum  (comb_sum),
        .nxt_cout (comb_cout),
        .q        (reg_sum),
        .qc       (reg_cout)
    );

    a_r9_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10 && ena && !sclr && !sload && cnt_en && !cnt_down)
        |=> (reg_sum == $past(reg_sum) + ONE));
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10 && ena && !sclr && !sload && cnt_en && cnt_down)
        |=> (reg_sum == $past(reg_sum) - ONE));
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |-> (reg_sum == '0 && !reg_cout));
endmodule

// File: tb/csel_addsub_test.sv
module csel_addsub_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic [W-1:0] data1 = '0, data2 = '0, load_val = '0;
    logic carry_in = 0, sub_en = 0, ena = 0, cnt_en = 0, cnt_down = 0, sclr = 0, sload = 0;
    logic [W-1:0] comb_sum, reg_sum;
    logic comb_cout, reg_cout;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    csel_addsub #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .data1(data1), .data2(data2),
        .carry_in(carry_in), .sub_en(sub_en), .ena(ena), .cnt_en(cnt_en),
        .cnt_down(cnt_down), .sclr(sclr), .sload(sload), .load_val(load_val),
        .comb_sum(comb_sum), .comb_cout(comb_cout), .reg_sum(reg_sum), .reg_cout(reg_cout)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [W:0] ref_sub(logic [W-1:0] x, logic [W-1:0] y);
        logic [W:0] r;
        r[W-1:0] = x - y;
        r[W] = (x >= y);
        return r;
    endfunction

    task automatic comb_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        op_mode = 2'b00; sub_en = 0; data1 = x; data2 = y; carry_in = c;
        #1 check("R1 add", {comb_cout, comb_sum}, ref_add(x, y, c));
    endtask

    task automatic comb_sub(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        op_mode = 2'b00; sub_en = 1; data1 = x; data2 = y; carry_in = c;
        #1 check("R2 sub", {comb_cout, comb_sum}, ref_sub(x, y));
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        ena = 1; sclr = 0; sload = 1; load_val = 8'h5A;
        #3 check("R11 reset", {reg_cout, reg_sum}, '0);
        @(negedge clk); sload = 0; ena = 0; rst_n = 1;
    endtask

    task automatic t_add;
        comb_add(8'hFF, 8'h00, 1'b1);
        comb_add(8'hFF, 8'hFF, 1'b1);
        comb_add(8'h00, 8'h00, 1'b0);
        comb_add(8'h80, 8'h80, 1'b0);
        for (int i = 0; i < 1500; i++) comb_add(W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_sub;
        comb_sub(8'h00, 8'h01, 1'b0);
        comb_sub(8'h00, 8'h01, 1'b1);
        comb_sub(8'h37, 8'h37, 1'b0);
        comb_sub(8'hFF, 8'h00, 1'b1);
        for (int i = 0; i < 1500; i++) comb_sub(W'($urandom), W'($urandom), 1'($urandom));
    endtask

    task automatic t_cin_flip;
        logic [W:0] lo;
        for (int i = 0; i < 200; i++) begin
            data1 = (i == 0) ? 8'hFF : W'($urandom);
            data2 = (i == 0) ? 8'h00 : W'($urandom);
            op_mode = 2'b00; sub_en = 0; carry_in = 0;
            #1 lo = {comb_cout, comb_sum};
            carry_in = 1;
            #1 check("R3 carry flip", {comb_cout, comb_sum}, lo + 1'b1);
        end
    endtask

    task automatic t_register;
        @(negedge clk);
        op_mode = 2'b00; sub_en = 0; data1 = 8'hF0; data2 = 8'h20; carry_in = 1; ena = 1;
        tick;
        check("R4 capture", {reg_cout, reg_sum}, 9'h111);
        @(negedge clk); sub_en = 1; data1 = 8'h10; data2 = 8'h20;
        tick;
        check("R4 capture sub", {reg_cout, reg_sum}, 9'h0F0);
    endtask

    task automatic t_priority;
        @(negedge clk); ena = 1; sclr = 1; sload = 1; load_val = 8'hA5;
        tick;
        check("R5 clear over load", {reg_cout, reg_sum}, '0);
        @(negedge clk); sclr = 0; sload = 1; op_mode = 2'b10; cnt_en = 1;
        tick;
        check("R6 load", {reg_cout, reg_sum}, {1'b0, 8'hA5});
        @(negedge clk); sload = 0; ena = 0; sclr = 1;
        tick;
        check("R7 hold sclr", {reg_cout, reg_sum}, {1'b0, 8'hA5});
        @(negedge clk); sclr = 0; sload = 1; load_val = 8'h11;
        tick;
        check("R7 hold sload", {reg_cout, reg_sum}, {1'b0, 8'hA5});
        @(negedge clk); sload = 0; op_mode = 2'b00; data1 = 8'h01; data2 = 8'h01;
        tick;
        check("R7 hold step", {reg_cout, reg_sum}, {1'b0, 8'hA5});
        cnt_en = 0;
    endtask

    task automatic t_accum;
        logic [W-1:0] m;
        logic [W:0] e;
        @(negedge clk); ena = 1; sclr = 1;
        tick;
        @(negedge clk); sclr = 0; op_mode = 2'b01; data1 = 8'hEE;
        m = '0;
        for (int i = 0; i < 40; i++) begin
            sub_en = 1'($urandom); carry_in = 1'($urandom); data2 = W'($urandom);
            e = sub_en ? ref_sub(m, data2) : ref_add(m, data2, carry_in);
            tick;
            check("R8 accumulate", {reg_cout, reg_sum}, e);
            m = e[W-1:0];
            @(negedge clk);
        end
    endtask

    task automatic t_count;
        @(negedge clk); ena = 1; sload = 1; load_val = 8'hFE; op_mode = 2'b10;
        tick;
        @(negedge clk); sload = 0; cnt_en = 1; cnt_down = 0;
        data1 = 8'h33; data2 = 8'h44; carry_in = 1; sub_en = 1;
        tick;
        check("R9 up", {1'b0, reg_sum}, {1'b0, 8'hFF});
        tick;
        check("R9 up wrap", {1'b0, reg_sum}, {1'b0, 8'h00});
        @(negedge clk); cnt_down = 1;
        tick;
        check("R9 down wrap", {1'b0, reg_sum}, {1'b0, 8'hFF});
        tick;
        check("R9 down", {1'b0, reg_sum}, {1'b0, 8'hFE});
        @(negedge clk); cnt_en = 0;
        tick;
        check("R10 count disabled", {1'b0, reg_sum}, {1'b0, 8'hFE});
        tick;
        check("R10 count disabled again", {1'b0, reg_sum}, {1'b0, 8'hFE});
        @(negedge clk); ena = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset;
        t_add;
        t_sub;
        t_cin_flip;
        t_register;
        t_priority;
        t_accum;
        t_count;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule